// File: doc/BRIEF.md
# Flow-Controlled Serial Character Buffer

This block sits between a host that writes and reads bytes and a serial transmitter/receiver pair. Outgoing bytes go into a transmit queue. The queue is emptied one byte per transmitter slot, which is a cycle in which the transmitter raises `tx_ready`. Incoming bytes from the receiver go into a receive queue, and the host drains that queue in first-word-fall-through style.

When `flow_en` is high, the block applies in-band software flow control. A received XOFF (8'h13) pauses outgoing data, and a received XON (8'h11) resumes it. Neither of these bytes is stored. The block also watches its own receive queue. It queues an XOFF for transmission when the queue is close to full, and an XON once the queue has drained again. A pending control byte takes the next transmitter slot ahead of queued data, and it is sent even while outgoing data is paused. When `flow_en` is low, every byte is plain data and nothing is inserted.

Top module: `uart_flow_buffer`

## Requirements
- R1: Reset state: `tx_valid` 0, `host_rd_valid` 0, `host_wr_ready` 1, `overrun` 0, `tx_paused` 0.
- R2: For each cycle with `tx_ready` high, data waiting, no control byte pending and no pause, `tx_valid` is 1 in the next cycle and `tx_data` holds the oldest queued byte. Bytes leave in write order. `tx_valid` is 0 in any cycle not preceded by a `tx_ready` cycle that had something to send.
- R3: Each received byte that is not consumed as control is appended to the receive queue. `host_rd_valid` is 1 while the queue is non-empty, and `host_rd_data` shows the oldest byte. `host_rd_ready` removes that byte.
- R4: With `flow_en` low, 8'h11 and 8'h13 are stored as ordinary data, `tx_paused` stays 0 and no control byte is inserted.
- R5: With `flow_en` high, a received 8'h13 is not stored. It sets `tx_paused` in the next cycle, and from then on no queued data is sent.
- R6: With `flow_en` high, a received 8'h11 is not stored. It clears `tx_paused` in the next cycle, and queued data flows again.
- R7: With `flow_en` high, once the receive queue has 10 or fewer free entries, one 8'h13 is queued for transmission. No further 8'h13 is sent until after an XON has been issued.
- R8: After a self-issued XOFF, one 8'h11 is queued once free space exceeds 20 entries. Nothing is queued at exactly 20 free entries.
- R9: A pending control byte wins the next `tx_ready` slot over queued data, and it is sent even while `tx_paused` is 1.
- R10: A byte that arrives while the receive queue holds DEPTH (64) entries is dropped, even if the host reads in the same cycle. It sets `overrun`, which stays 1 until reset.
- R11: The transmit queue holds DEPTH (64) bytes. `host_wr_ready` is 0 while it is full, and a write made then is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_en | input | 1 | Enables XON/XOFF handling |
| host_wr_valid | input | 1 | Host writes a byte to the transmit queue |
| host_wr_data | input | 8 | Byte to transmit |
| host_wr_ready | output | 1 | Transmit queue has room |
| host_rd_ready | input | 1 | Host takes the oldest received byte |
| host_rd_valid | output | 1 | Receive queue non-empty |
| host_rd_data | output | 8 | Oldest received byte |
| rx_valid | input | 1 | Receiver delivers a byte this cycle |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter slot: may accept one byte |
| tx_valid | output | 1 | Byte issued to the transmitter |
| tx_data | output | 8 | Issued byte |
| tx_paused | output | 1 | Outgoing data held by a received XOFF |
| overrun | output | 1 | Sticky receive-drop flag |

## Verification
The assertions assume that `tx_ready` is a per-cycle slot indication, so two consecutive high cycles ask for two bytes. They also assume that `rx_valid` carries at most one byte per cycle, and that `flow_en` is driven synchronously to the clock. The bench changes all of these inputs only on the falling edge and holds them for whole cycles. A cycle-level reference model runs in lockstep with the design. Its random traffic mixes control codes into the receive data and toggles `flow_en` occasionally. Directed sequences walk the receive queue across both thresholds, into overflow, and fill the transmit queue.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam logic [7:0] XON_CODE  = 8'h11;
  localparam logic [7:0] XOFF_CODE = 8'h13;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/ufb_fifo.sv
module ufb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic push_ok, pop_ok;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign rdata   = mem[rptr];

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ufb_flow_ctrl.sv
module ufb_flow_ctrl
  import uart_fc_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int XOFF_FREE = 10,
  parameter int XON_FREE  = 20,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flow_en,
  input  logic          rx_valid,
  input  byte_t         rx_data,
  input  logic [CW-1:0] rx_count,
  input  logic          ctrl_take,
  output logic          rx_store,
  output logic          paused,
  output logic          ctrl_pend,
  output byte_t         ctrl_char
);
  logic is_ctrl, xoff_sent, need_xoff, need_xon;
  logic [CW-1:0] free_slots;

  always_comb begin
    is_ctrl    = flow_en && (rx_data == XON_CODE || rx_data == XOFF_CODE);
    rx_store   = rx_valid && !is_ctrl;
    free_slots = CW'(DEPTH) - rx_count;
    need_xoff  = !xoff_sent && (free_slots <= CW'(XOFF_FREE));
    need_xon   = xoff_sent && (free_slots > CW'(XON_FREE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      paused    <= 1'b0;
      xoff_sent <= 1'b0;
      ctrl_pend <= 1'b0;
      ctrl_char <= XOFF_CODE;
    end else if (!flow_en) begin
      paused    <= 1'b0;
      xoff_sent <= 1'b0;
      ctrl_pend <= 1'b0;
    end else begin
      if (rx_valid && is_ctrl) paused <= (rx_data == XOFF_CODE);
      if (need_xoff) begin
        ctrl_pend <= 1'b1;
        ctrl_char <= XOFF_CODE;
        xoff_sent <= 1'b1;
      end else if (need_xon) begin
        ctrl_pend <= 1'b1;
        ctrl_char <= XON_CODE;
        xoff_sent <= 1'b0;
      end else if (ctrl_take) begin
        ctrl_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_flow_buffer.sv
module uart_flow_buffer
  import uart_fc_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int XOFF_FREE = 10,
  parameter int XON_FREE  = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flow_en,
  input  logic       host_wr_valid,
  input  logic [7:0] host_wr_data,
  output logic       host_wr_ready,
  input  logic       host_rd_ready,
  output logic       host_rd_valid,
  output logic [7:0] host_rd_data,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_paused,
  output logic       overrun
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] tx_count, rx_count;
  byte_t tx_head, ctrl_char;
  logic tx_empty, rx_full, rx_store, paused, ctrl_pend;
  logic slot_ctrl, slot_data;

  assign tx_empty = (tx_count == '0);
  assign rx_full  = (rx_count == CW'(DEPTH));

  ufb_fifo #(.WIDTH(8), .DEPTH(DEPTH)) tx_q_i (
    .clk(clk), .rst(rst),
    .push(host_wr_valid), .wdata(host_wr_data),
    .pop(slot_data), .rdata(tx_head), .count(tx_count)
  );

  ufb_fifo #(.WIDTH(8), .DEPTH(DEPTH)) rx_q_i (
    .clk(clk), .rst(rst),
    .push(rx_store), .wdata(rx_data),
    .pop(host_rd_ready), .rdata(host_rd_data), .count(rx_count)
  );

  ufb_flow_ctrl #(.DEPTH(DEPTH), .XOFF_FREE(XOFF_FREE), .XON_FREE(XON_FREE)) fc_i (
    .clk(clk), .rst(rst), .flow_en(flow_en),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_count(rx_count),
    .ctrl_take(slot_ctrl), .rx_store(rx_store), .paused(paused),
    .ctrl_pend(ctrl_pend), .ctrl_char(ctrl_char)
  );

  // control byte outranks data and ignores the pause
  assign slot_ctrl = tx_ready && ctrl_pend;
  assign slot_data = tx_ready && !ctrl_pend && !paused && !tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      overrun  <= 1'b0;
    end else begin
      tx_valid <= slot_ctrl || slot_data;
      if (slot_ctrl)      tx_data <= ctrl_char;
      else if (slot_data) tx_data <= tx_head;
      if (rx_store && rx_full) overrun <= 1'b1;
    end
  end

  assign host_wr_ready = (tx_count != CW'(DEPTH));
  assign host_rd_valid = (rx_count != '0);
  assign tx_paused     = paused;
endmodule

// File: rtl/uart_flow_buffer_chk.sv
module uart_flow_buffer_chk
  import uart_fc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       flow_en,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_paused,
  input logic       overrun
);
  p_tx_needs_slot_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(tx_ready));

  p_flow_off_unpaused_r4: assert property (@(posedge clk) disable iff (rst)
    !flow_en |=> !tx_paused);

  p_xoff_pauses_r5: assert property (@(posedge clk) disable iff (rst)
    (flow_en && rx_valid && rx_data == XOFF_CODE) |=> tx_paused);

  p_xon_resumes_r6: assert property (@(posedge clk) disable iff (rst)
    (flow_en && rx_valid && rx_data == XON_CODE) |=> !tx_paused);

  p_paused_ctrl_only_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && $past(tx_paused)) |-> (tx_data == XON_CODE || tx_data == XOFF_CODE));

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind uart_flow_buffer uart_flow_buffer_chk chk_i (
  .clk(clk), .rst(rst), .flow_en(flow_en), .rx_valid(rx_valid), .rx_data(rx_data),
  .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_paused(tx_paused), .overrun(overrun)
);

// File: tb/uart_flow_buffer_tb_top.sv
`timescale 1ns/1ps
module uart_flow_buffer_tb_top;
  localparam int DEPTH = 64;
  localparam logic [7:0] XON = 8'h11, XOFF = 8'h13;

  logic clk = 0, rst = 1, flow_en = 0;
  logic host_wr_valid = 0, host_rd_ready = 0, rx_valid = 0, tx_ready = 0;
  logic [7:0] host_wr_data = 0, rx_data = 0;
  logic host_wr_ready, host_rd_valid, tx_valid, tx_paused, overrun;
  logic [7:0] host_rd_data, tx_data;

  always #2.5 clk = ~clk;

  uart_flow_buffer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .flow_en(flow_en),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data), .host_wr_ready(host_wr_ready),
    .host_rd_ready(host_rd_ready), .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_paused(tx_paused), .overrun(overrun)
  );

  int checks = 0, fails = 0;
  bit chk_en = 0, done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, written from the requirements
  logic [7:0] tx_q[$], rx_q[$];
  bit m_paused, m_xsent, m_pend, m_overrun, m_tv, m_tctrl;
  logic [7:0] m_pchar, m_td;

  always @(posedge clk) begin
    int txn, rxn;
    if (rst) begin
      tx_q.delete(); rx_q.delete();
      m_paused = 0; m_xsent = 0; m_pend = 0; m_overrun = 0; m_tv = 0; m_tctrl = 0;
      m_pchar = XOFF; m_td = 0;
    end else begin
      txn = tx_q.size(); rxn = rx_q.size();
      m_tv = 0; m_tctrl = 0;
      if (tx_ready) begin
        if (m_pend) begin m_tv = 1; m_tctrl = 1; m_td = m_pchar; m_pend = 0; end
        else if (!m_paused && txn > 0) begin m_tv = 1; m_td = tx_q.pop_front(); end
      end
      if (host_wr_valid && txn < DEPTH) tx_q.push_back(host_wr_data);
      if (rx_valid && flow_en && (rx_data == XON || rx_data == XOFF))
        m_paused = (rx_data == XOFF);
      else if (rx_valid) begin
        if (rxn < DEPTH) rx_q.push_back(rx_data); else m_overrun = 1;
      end
      if (host_rd_ready && rxn > 0) void'(rx_q.pop_front());
      if (!flow_en) begin
        m_paused = 0; m_xsent = 0; m_pend = 0;
      end else if (!m_xsent && DEPTH - rxn <= 10) begin
        m_pend = 1; m_pchar = XOFF; m_xsent = 1;
      end else if (m_xsent && DEPTH - rxn > 20) begin
        m_pend = 1; m_pchar = XON; m_xsent = 0;
      end
    end
  end

  always @(negedge clk) begin
    string tg;
    if (chk_en && !rst && !done) begin
      tg = m_tctrl ? ((m_td == XOFF) ? "R7 tx" : "R8 tx") : "R2 tx";
      chk(tg, tx_valid, m_tv);
      if (m_tv) chk(tg, tx_data, m_td);
      chk("R3 rd_valid", host_rd_valid, rx_q.size() > 0);
      if (rx_q.size() > 0) chk("R3 rd_data", host_rd_data, rx_q[0]);
      chk("R11 wr_ready", host_wr_ready, tx_q.size() < DEPTH);
      chk("R10 overrun", overrun, m_overrun);
      chk("R5 paused", tx_paused, m_paused);
    end
  end

  task automatic drive(bit rv, logic [7:0] rd, bit wv, logic [7:0] wd, bit tr, bit rr);
    @(negedge clk);
    rx_valid = rv; rx_data = rd; host_wr_valid = wv; host_wr_data = wd;
    tx_ready = tr; host_rd_ready = rr;
  endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0); endtask
  task automatic slot(); drive(0, 0, 0, 0, 1, 0); idle(1); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0; chk_en = 1;
    // R1 reset state
    chk("R1 tx_valid", tx_valid, 0); chk("R1 rd_valid", host_rd_valid, 0);
    chk("R1 wr_ready", host_wr_ready, 1); chk("R1 overrun", overrun, 0);
    chk("R1 paused", tx_paused, 0);

    // R4 flow off: codes are data
    drive(1, XOFF, 0, 0, 0, 0); drive(1, XON, 0, 0, 0, 0); idle(1);
    chk("R4 stored", host_rd_data, XOFF); chk("R4 paused", tx_paused, 0);
    drive(0, 0, 0, 0, 0, 1); idle(1);
    chk("R4 stored", host_rd_data, XON);
    drive(0, 0, 0, 0, 0, 1); idle(1);
    chk("R3 empty", host_rd_valid, 0);

    // R2 transmit order
    drive(0, 0, 1, 8'hA1, 0, 0); drive(0, 0, 1, 8'hA2, 0, 0); drive(0, 0, 1, 8'hA3, 0, 0);
    slot(); chk("R2 first", tx_data, 8'hA1);
    slot(); chk("R2 second", tx_data, 8'hA2);
    slot(); chk("R2 third", tx_data, 8'hA3);
    slot(); chk("R2 nothing", tx_valid, 0);

    // R5 / R6
    flow_en = 1;
    drive(1, XOFF, 0, 0, 0, 0); idle(1);
    chk("R5 paused", tx_paused, 1); chk("R5 not stored", host_rd_valid, 0);
    drive(0, 0, 1, 8'hB1, 0, 0); slot(); chk("R5 held", tx_valid, 0);
    drive(1, XON, 0, 0, 0, 0); idle(1);
    chk("R6 resumed", tx_paused, 0); chk("R6 not stored", host_rd_valid, 0);
    slot(); chk("R6 flows", tx_data, 8'hB1);

    // R7 / R9 / R10 / R8
    drive(1, XOFF, 1, 8'hC1, 0, 0);
    for (int i = 0; i < 54; i++) drive(1, 8'h40 + 8'(i), 0, 0, 0, 0);
    idle(3);
    slot(); chk("R9 ctrl first", tx_valid, 1); chk("R7 xoff", tx_data, XOFF);
    slot(); chk("R7 once", tx_valid, 0);
    for (int i = 0; i < 12; i++) drive(1, 8'h80 + 8'(i), 0, 0, 0, 0);
    idle(1);
    chk("R10 overrun", overrun, 1); chk("R10 head kept", host_rd_data, 8'h40);
    for (int i = 0; i < 20; i++) drive(0, 0, 0, 0, 0, 1);
    idle(3); slot(); chk("R8 not at 20", tx_valid, 0);
    drive(0, 0, 0, 0, 0, 1); idle(3);
    slot(); chk("R8 xon", tx_data, XON);
    slot(); chk("R8 once", tx_valid, 0);
    drive(1, XON, 0, 0, 0, 0); idle(1);
    slot(); chk("R6 data after xon", tx_data, 8'hC1);
    for (int i = 0; i < 43; i++) drive(0, 0, 0, 0, 0, 1);
    idle(1); chk("R10 sticky", overrun, 1);

    // R11 transmit full
    for (int i = 0; i < DEPTH; i++) drive(0, 0, 1, 8'(i), 0, 0);
    idle(1); chk("R11 full", host_wr_ready, 0);
    drive(0, 0, 1, 8'hEE, 0, 0);
    for (int i = 0; i < DEPTH; i++) drive(0, 0, 0, 0, 1, 0);
    idle(1);
    slot(); chk("R11 extra dropped", tx_valid, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] rd;
      int r = $urandom_range(0, 9);
      rd = (r == 0) ? XON : (r == 1) ? XOFF : 8'($urandom);
      if ($urandom_range(0, 199) == 0) flow_en = ~flow_en;
      drive($urandom_range(0, 9) < 3, rd, $urandom_range(0, 9) < 4, 8'($urandom),
            $urandom_range(0, 9) < 4, $urandom_range(0, 9) < ((i < 2000) ? 2 : 6));
    end
    idle(4);
    finish_run();
  end
endmodule